// File: doc/BRIEF.md
# Calibrated Bank Temperature Converter

This block turns a bank of raw thermal-sensor codes into signed temperatures in millidegrees Celsius and reports the hottest reading of the bank. A host pulses `start` with up to `NSENS` raw codes, a sensor count and a set of per-device calibration values: gain error, one reference code per sensor, calibration temperature, a signed slope trim and the slope coefficient. The block then works through the bank one sensor after another and raises `done` for one cycle when every result is in place.

The conversion uses fixed-point integer arithmetic. A large constant is divided by the trimmed slope and then by the gain term. The quotient scales the distance of the masked raw code from its reference. An arithmetic right shift and a subtraction from the scaled calibration temperature give the result. The two divides depend only on calibration, so one shared iterative divider computes them once per bank. The first reading after power-up is often implausibly hot, so any result above 200 °C is replaced by zero before the bank maximum is formed. When `cal_valid` is low, a fixed default calibration set is used in place of the calibration ports.

Top module: `tconv_bank`

## Requirements
- R1: Only the low 12 bits of each 16-bit raw code enter the conversion; bits 15:12 have no effect on any result.
- R2: Each result equals T*500 - ((Q * (raw - ref - 3350)) >>> 3), with Q = (1627604160 / (coef + trim)) / (10000 + gain). All arithmetic is 32-bit two's complement, each division truncates toward zero, and the product wraps to 32 bits.
- R3: A converted value greater than 200000 is reported as 0; a value of 200000 or less is reported unchanged.
- R4: `temp_max` is the largest filtered result among the active sensors, starting from -2147483648; with a count of 0 it reads -2147483648 (0x80000000).
- R5: A count above `NSENS` is treated as `NSENS`; slots at or above the active count read 0 after the run.
- R6: `done` is high for exactly one cycle, 68 + n clock cycles after the edge that accepted `start`, where n is the active count (68 = two divides of 34 cycles each).
- R7: A `start` pulse while a run is in progress is ignored: the results and the `done` timing of the current run are unchanged and no second `done` follows.
- R8: All data and calibration inputs are captured on the accepting edge; changing them later in the run does not alter the results.
- R9: After reset `done` is low and every result and `temp_max` read 0.
- R10: When `cal_valid` is low at acceptance, gain 512, reference 260 for every sensor, calibration temperature 40 and trim 0 are used whatever the calibration ports carry; `slope_coef` is always taken from its port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a bank conversion (taken only when idle) |
| sens_cnt | input | CNT_W | Number of sensors to convert |
| raw_codes | input | NSENS*RAW_IN_W | Raw codes, sensor i at bits [i*16 +: 16] |
| cal_valid | input | 1 | Calibration ports valid; low selects defaults |
| cal_gain_err | input | GE_W | Gain error (unsigned) |
| cal_ref | input | NSENS*REF_W | Per-sensor reference code, sensor i at [i*9 +: 9] |
| cal_temp | input | CT_W | Calibration temperature in degrees (unsigned) |
| cal_trim | input | TRIM_W | Signed slope trim |
| slope_coef | input | COEF_W | Slope coefficient (for example 165 or 153) |
| temp_out | output | NSENS*32 | Per-sensor filtered results, sensor i at [i*32 +: 32] |
| temp_max | output | 32 | Bank maximum |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is a second `start` or changed inputs arriving while the shared divider is partway through its first quotient. The bench counts cycles from the accepting edge and drives the interfering pulse and the altered raw and calibration words on a chosen cycle, then compares the run's results and `done` timing with the undisturbed values. The plausibility threshold is reached by choosing raw codes whose converted value lies just above and just below 200000 under the default calibration. A zero count is used to observe the bare initial value of the maximum.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

  localparam int unsigned DATA_W = 32;

  // Conversion constants
  localparam logic signed [DATA_W-1:0] NUM_K       = 32'sd1627604160;
  localparam logic signed [DATA_W-1:0] GAIN_BASE   = 32'sd10000;
  localparam logic signed [DATA_W-1:0] CODE_OFFSET = 32'sd3350;
  localparam logic signed [DATA_W-1:0] TEMP_SCALE  = 32'sd500;
  localparam logic signed [DATA_W-1:0] BOGUS_LIMIT = 32'sd200000;
  localparam int unsigned              FRAC_SHIFT  = 3;
  localparam logic signed [DATA_W-1:0] MAX_SEED    = 32'sh8000_0000;

  // Fallback calibration
  localparam int unsigned DEF_GAIN = 512;
  localparam int unsigned DEF_REF  = 260;
  localparam int unsigned DEF_TEMP = 40;
  localparam int          DEF_TRIM = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV1 = 2'd1,
    ST_DIV2 = 2'd2,
    ST_CONV = 2'd3
  } phase_t;

endpackage

// File: rtl/tconv_divider.sv
module tconv_divider #(
  parameter int unsigned W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                go,
  input  logic signed [W-1:0] dividend,
  input  logic signed [W-1:0] divisor,
  output logic signed [W-1:0] quot,
  output logic                done
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     rem_q, dvd_q, dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, neg_q, zero_q;

  logic [W:0]   trial, diff;
  logic         fits;
  logic [W-1:0] rem_nxt, dvd_nxt, mag_a, mag_b;

  always_comb begin
    mag_a   = dividend[W-1] ? (W'(0) - dividend) : dividend;
    mag_b   = divisor[W-1]  ? (W'(0) - divisor)  : divisor;
    trial   = {rem_q, dvd_q[W-1]};
    diff    = trial - {1'b0, dsr_q};
    fits    = ~diff[W];
    rem_nxt = fits ? diff[W-1:0] : trial[W-1:0];
    dvd_nxt = {dvd_q[W-2:0], fits};
  end

  // Restoring division, one quotient bit per cycle; zero divisor yields 0
  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      dsr_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
      quot   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        rem_q  <= '0;
        dvd_q  <= mag_a;
        dsr_q  <= mag_b;
        neg_q  <= dividend[W-1] ^ divisor[W-1];
        zero_q <= (divisor == '0);
      end else if (busy_q) begin
        rem_q <= rem_nxt;
        dvd_q <= dvd_nxt;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
          quot   <= zero_q ? '0 : (neg_q ? (W'(0) - dvd_nxt) : dvd_nxt);
        end
      end
    end
  end

  AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DIV_LAUNCH: assert property (@(posedge clk) disable iff (rst)
    (go && !busy_q) |=> (busy_q && !done)); // R6

endmodule

// File: rtl/tconv_point.sv
module tconv_point
  import tconv_pkg::*;
#(
  parameter int unsigned RAW_W = 12,
  parameter int unsigned REF_W = 9,
  parameter int unsigned CT_W  = 6
) (
  input  logic        [RAW_W-1:0]  raw,
  input  logic        [REF_W-1:0]  ref_code,
  input  logic        [CT_W-1:0]   cal_temp,
  input  logic signed [DATA_W-1:0] scale,
  output logic signed [DATA_W-1:0] val
);
  logic signed [DATA_W-1:0] delta, prod, term, base, conv;

  always_comb begin
    delta = $signed({{(DATA_W-RAW_W){1'b0}}, raw})
          - $signed({{(DATA_W-REF_W){1'b0}}, ref_code})
          - CODE_OFFSET;
    prod  = scale * delta;
    term  = prod >>> FRAC_SHIFT;
    base  = $signed({{(DATA_W-CT_W){1'b0}}, cal_temp}) * TEMP_SCALE;
    conv  = base - term;
    val   = (conv > BOGUS_LIMIT) ? '0 : conv;
  end

endmodule

// File: rtl/tconv_bank.sv
module tconv_bank
  import tconv_pkg::*;
#(
  parameter int unsigned NSENS    = 4,
  parameter int unsigned RAW_IN_W = 16,
  parameter int unsigned RAW_W    = 12,
  parameter int unsigned GE_W     = 10,
  parameter int unsigned REF_W    = 9,
  parameter int unsigned CT_W     = 6,
  parameter int unsigned TRIM_W   = 7,
  parameter int unsigned COEF_W   = 8,
  localparam int unsigned CNT_W   = $clog2(NSENS + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [CNT_W-1:0]           sens_cnt,
  input  logic [NSENS*RAW_IN_W-1:0]  raw_codes,
  input  logic                       cal_valid,
  input  logic [GE_W-1:0]            cal_gain_err,
  input  logic [NSENS*REF_W-1:0]     cal_ref,
  input  logic [CT_W-1:0]            cal_temp,
  input  logic signed [TRIM_W-1:0]   cal_trim,
  input  logic [COEF_W-1:0]          slope_coef,
  output logic [NSENS*DATA_W-1:0]    temp_out,
  output logic signed [DATA_W-1:0]   temp_max,
  output logic                       done
);
  localparam int unsigned IDX_W = (NSENS > 1) ? $clog2(NSENS) : 1;
  localparam logic [CNT_W-1:0] NS_MAX = CNT_W'(NSENS);

  phase_t st_q;
  logic [CNT_W-1:0]  n_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RAW_W-1:0]  raw_q [NSENS];
  logic [REF_W-1:0]  ref_q [NSENS];
  logic [GE_W-1:0]   ge_q;
  logic [CT_W-1:0]   temp_q;
  logic signed [TRIM_W-1:0] trim_q;
  logic [COEF_W-1:0] coef_q;
  logic signed [DATA_W-1:0] q1_q, scale_q, max_q;
  logic signed [DATA_W-1:0] res_q [NSENS];
  logic div_go_q, done_q;

  logic [RAW_W-1:0] raw_in [NSENS];
  logic [REF_W-1:0] ref_in [NSENS];
  logic [NSENS*(RAW_IN_W-RAW_W)-1:0] raw_hi_unused;

  // Unpack inputs, keep low code bits, pack results
  for (genvar i = 0; i < NSENS; i++) begin : g_lane
    assign raw_in[i] = raw_codes[i*RAW_IN_W +: RAW_W];
    assign raw_hi_unused[i*(RAW_IN_W-RAW_W) +: (RAW_IN_W-RAW_W)] =
      raw_codes[i*RAW_IN_W+RAW_W +: (RAW_IN_W-RAW_W)];
    assign ref_in[i] = cal_ref[i*REF_W +: REF_W];
    assign temp_out[i*DATA_W +: DATA_W] = res_q[i];
  end

  // Shared divider operand selection
  logic signed [DATA_W-1:0] div_dvd, div_dsr, div_quot;
  logic                     div_done;
  logic signed [DATA_W-1:0] coef_ext, trim_ext, gain_ext;

  always_comb begin
    coef_ext = $signed({{(DATA_W-COEF_W){1'b0}}, coef_q});
    trim_ext = {{(DATA_W-TRIM_W){trim_q[TRIM_W-1]}}, trim_q};
    gain_ext = $signed({{(DATA_W-GE_W){1'b0}}, ge_q});
    if (st_q == ST_DIV2) begin
      div_dvd = q1_q;
      div_dsr = GAIN_BASE + gain_ext;
    end else begin
      div_dvd = NUM_K;
      div_dsr = coef_ext + trim_ext;
    end
  end

  tconv_divider #(.W(DATA_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .go       (div_go_q),
    .dividend (div_dvd),
    .divisor  (div_dsr),
    .quot     (div_quot),
    .done     (div_done)
  );

  logic signed [DATA_W-1:0] pt_val;

  tconv_point #(.RAW_W(RAW_W), .REF_W(REF_W), .CT_W(CT_W)) u_point (
    .raw      (raw_q[idx_q]),
    .ref_code (ref_q[idx_q]),
    .cal_temp (temp_q),
    .scale    (scale_q),
    .val      (pt_val)
  );

  logic last_pt;
  assign last_pt = ({{(CNT_W-IDX_W){1'b0}}, idx_q} == (n_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      n_q      <= '0;
      idx_q    <= '0;
      ge_q     <= '0;
      temp_q   <= '0;
      trim_q   <= '0;
      coef_q   <= '0;
      q1_q     <= '0;
      scale_q  <= '0;
      max_q    <= '0;
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      for (int i = 0; i < NSENS; i++) begin
        raw_q[i] <= '0;
        ref_q[i] <= '0;
        res_q[i] <= '0;
      end
    end else begin
      div_go_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            n_q      <= (sens_cnt > NS_MAX) ? NS_MAX : sens_cnt;
            coef_q   <= slope_coef;
            ge_q     <= cal_valid ? cal_gain_err : GE_W'(DEF_GAIN);
            temp_q   <= cal_valid ? cal_temp     : CT_W'(DEF_TEMP);
            trim_q   <= cal_valid ? cal_trim     : TRIM_W'(DEF_TRIM);
            for (int i = 0; i < NSENS; i++) begin
              raw_q[i] <= raw_in[i];
              ref_q[i] <= cal_valid ? ref_in[i] : REF_W'(DEF_REF);
              res_q[i] <= '0;
            end
            max_q    <= MAX_SEED;
            idx_q    <= '0;
            div_go_q <= 1'b1;
            st_q     <= ST_DIV1;
          end
        end
        ST_DIV1: begin
          if (div_done) begin
            q1_q     <= div_quot;
            div_go_q <= 1'b1;
            st_q     <= ST_DIV2;
          end
        end
        ST_DIV2: begin
          if (div_done) begin
            scale_q <= div_quot;
            idx_q   <= '0;
            if (n_q == '0) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_CONV;
            end
          end
        end
        ST_CONV: begin
          res_q[idx_q] <= pt_val;
          if (pt_val > max_q) max_q <= pt_val;
          if (last_pt) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign temp_max = max_q;
  assign done     = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (st_q == ST_IDLE)); // R6
  AST_FILTER_CAP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV) |-> (pt_val <= BOGUS_LIMIT)); // R3
  AST_MAX_RISES: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CONV) |=> (max_q >= $past(max_q))); // R4
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |=> ($stable(n_q) && $stable(temp_q) && $stable(ge_q))); // R7
  AST_COUNT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (st_q != ST_IDLE) |-> (n_q <= NS_MAX)); // R5

endmodule

// File: tb/sim_tconv_bank.sv
module sim_tconv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] sens_cnt = '0;
  logic [NS*16-1:0] raw_codes = '0;
  logic cal_valid = 1'b0;
  logic [9:0] cal_gain_err = '0;
  logic [NS*9-1:0] cal_ref = '0;
  logic [5:0] cal_temp = '0;
  logic signed [6:0] cal_trim = '0;
  logic [7:0] slope_coef = '0;
  logic [NS*32-1:0] temp_out;
  logic signed [31:0] temp_max;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tconv_bank u0 (
    .clk(clk), .rst(rst), .start(start), .sens_cnt(sens_cnt),
    .raw_codes(raw_codes), .cal_valid(cal_valid), .cal_gain_err(cal_gain_err),
    .cal_ref(cal_ref), .cal_temp(cal_temp), .cal_trim(cal_trim),
    .slope_coef(slope_coef), .temp_out(temp_out), .temp_max(temp_max),
    .done(done)
  );

  typedef struct packed {
    logic [2:0]  cnt;
    logic [15:0] r0, r1, r2, r3;
    logic        cv;
    logic [9:0]  ge;
    logic [8:0]  rf;
    logic [5:0]  tp;
    logic [6:0]  tr;
    logic [7:0]  cf;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{3'd4, 16'd3610, 16'd4095, 16'd2000, 16'd1000, 1'b0, 10'd77,   9'd13,  6'd9,  7'd5,   8'd165},
    '{3'd4, 16'hF0E2, 16'hA800, 16'h5FFF, 16'h1234, 1'b1, 10'd300,  9'd200, 6'd45, -7'sd20, 8'd153},
    '{3'd2, 16'd0,    16'd3000, 16'd500,  16'd600,  1'b1, 10'd1023, 9'd511, 6'd63, 7'sd63, 8'd165},
    '{3'd3, 16'd4095, 16'd4090, 16'd4000, 16'd10,   1'b1, 10'd0,    9'd0,   6'd0,  7'd0,   8'd165},
    '{3'd7, 16'd3700, 16'd3500, 16'd3900, 16'd3300, 1'b0, 10'd0,    9'd0,   6'd0,  7'd0,   8'd153},
    '{3'd1, 16'd2075, 16'd100,  16'd200,  16'd300,  1'b0, 10'd0,    9'd0,   6'd0,  7'd0,   8'd165},
    '{3'd4, 16'd2070, 16'd2073, 16'd2077, 16'd2080, 1'b0, 10'd0,    9'd0,   6'd0,  7'd0,   8'd165}
  };

  // Reference model built from the requirement text
  function automatic int model(logic [15:0] raw_in, int rf, int tp, int ge, int tr, int cf);
    int r, q, t, v;
    r = int'(raw_in & 16'h0FFF);
    q = 1627604160;
    q = q / (cf + tr);
    q = q / (10000 + ge);
    t = q * (r - rf - 3350);
    t = t >>> 3;
    v = tp * 500 - t;
    if (v > 200000) v = 0;
    return v;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    raw_codes    = {v.r3, v.r2, v.r1, v.r0};
    sens_cnt     = v.cnt;
    cal_valid    = v.cv;
    cal_gain_err = v.ge;
    cal_temp     = v.tp;
    cal_trim     = v.tr;
    slope_coef   = v.cf;
    for (int i = 0; i < NS; i++) cal_ref[i*9 +: 9] = 9'((int'(v.rf) + 11*i) % 512);
  endtask

  // Launch a run; optionally disturb inputs (and start) on cycle poke.
  task automatic run(vec_t v, int poke, bit poke_start, output int lat);
    int cyc;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    lat = -1;
    while (cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (done) begin
        lat = cyc;
        break;
      end
      if (cyc == poke) begin
        raw_codes    = ~raw_codes;
        cal_gain_err = cal_gain_err ^ 10'h155;
        cal_temp     = cal_temp ^ 6'h2A;
        cal_ref      = ~cal_ref;
        sens_cnt     = 3'd1;
        cal_valid    = ~cal_valid;
        start        = poke_start;
      end
      if (cyc == poke + 1) start = 1'b0;
    end
  endtask

  task automatic check_vec(vec_t v, int lat, string tag);
    int n, exp, mx, rf, tp, ge, tr;
    n  = (int'(v.cnt) > NS) ? NS : int'(v.cnt);
    ge = v.cv ? int'(v.ge) : 512;
    tp = v.cv ? int'(v.tp) : 40;
    tr = v.cv ? int'($signed(v.tr)) : 0;
    mx = 32'h8000_0000;
    chk("R6", {tag, " latency"}, lat, 68 + n);
    for (int i = 0; i < NS; i++) begin
      rf = v.cv ? ((int'(v.rf) + 11*i) % 512) : 260;
      if (i < n) begin
        exp = model(raw_codes_of(v, i), rf, tp, ge, tr, int'(v.cf));
        if (exp > mx) mx = exp;
      end else begin
        exp = 0;
      end
      // R1 R2 R3 R5 R10: per-slot conversion, masking, filter and clamp
      chk("R2", $sformatf("%s slot %0d", tag, i), int'(temp_out[i*32 +: 32]), exp);
    end
    chk("R4", {tag, " max"}, int'(temp_max), mx);
  endtask

  function automatic logic [15:0] raw_codes_of(vec_t v, int i);
    case (i)
      0: return v.r0;
      1: return v.r1;
      2: return v.r2;
      default: return v.r3;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int lat, ndone;
    vec_t v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state
    chk("R9", "done", int'(done), 0);
    chk("R9", "max", int'(temp_max), 0);
    for (int i = 0; i < NS; i++) chk("R9", "slot", int'(temp_out[i*32 +: 32]), 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R10
    for (int k = 0; k < NVEC; k++) begin
      run(VECS[k], -10, 1'b0, lat);
      check_vec(VECS[k], lat, $sformatf("vec%0d", k));
    end

    // R4 R6: zero count leaves the seed as maximum
    v = VECS[0];
    v.cnt = 3'd0;
    run(v, -10, 1'b0, lat);
    chk("R6", "zero count latency", lat, 68);
    chk("R4", "zero count max", int'(temp_max), 32'h8000_0000);

    // R8: inputs changed mid-division do not matter
    run(VECS[1], 20, 1'b0, lat);
    check_vec(VECS[1], lat, "R8 hold");

    // R7: start during a run is ignored
    run(VECS[3], 40, 1'b1, lat);
    check_vec(VECS[3], lat, "R7 busy");
    ndone = 0;
    for (int c = 0; c < 90; c++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk("R7", "extra done count", ndone, 0);
    chk("R7", "slot0 after ignore",
        int'(temp_out[31:0]), model(VECS[3].r0, 0, 0, 0, 0, 165));

    // R3: filtered first reading gives 0 in its slot
    chk("R3", "bogus raw 0 gives 0", model(16'd0, 260, 40, 512, 0, 165), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule